// File: doc/BRIEF.md
# I2C Master Command Sequencer

This block is the command-level controller of an I2C master. It sits between a CPU-side control interface and a byte-level bus engine. Software picks a transfer direction with a select bit and writes a 4-bit control word. The block decodes that word against its current mode (Idle, Transmit or Receive) and expands it into an ordered list of bus primitives. These are start or repeated start (which also carries the address), send byte, receive byte answered with ACK or NACK, and stop. Each primitive goes to the byte engine through a request/done handshake, and the engine reports NACK and arbitration loss on the done cycle.

The same control pattern means different bus sequences in each mode. For example, RUN alone sends a byte in Transmit and receives one in Receive. Illegal and unlisted combinations are dropped without side effects. A 7-bit status word reports progress and error causes. A sticky interrupt flags every finished or aborted command.

Top module: `i2c_cmd_seq`

## Requirements
- R1: Control word bits are RUN=bit0, START=bit1, STOP=bit2, ACK=bit3; rd_sel=1 selects receive. Engine op codes are 0 start, 1 repeated start, 2 send, 3 receive+ACK, 4 receive+NACK, 5 stop. In Idle with START and RUN set and rd_sel=0, STOP=0 issues ops 0,2 and ends in Transmit, and STOP=1 issues ops 0,2,5 and ends in Idle. ACK has no effect in either case.
- R2: In Idle with START and RUN set and rd_sel=1, the command issues op 0 then op 4 (ACK=0) or op 3 (ACK=1). STOP=0 ends in Receive. STOP=1 with ACK=0 adds op 5 and ends in Idle. STOP=1 with ACK=1 is illegal.
- R3: In Transmit, RUN alone sends (op 2) and stays. STOP alone issues op 5 and goes to Idle. STOP+RUN issues ops 2,5 and goes to Idle. START+RUN issues op 1 and then decodes direction, ACK and STOP as in R1/R2.
- R4: In Receive, RUN alone receives with op 3 or op 4 according to ACK and stays. STOP alone issues op 5 and goes to Idle. STOP+RUN with ACK=0 issues ops 4,5 and goes to Idle, and with ACK=1 it is illegal. START+RUN issues op 1 and then decodes as in R1/R2.
- R5: Illegal or unlisted commands, and any control write made while BUSY=1, cause no request, no mode change and no interrupt.
- R6: eng_req stays high with a stable eng_op until eng_done. Primitives are issued one at a time in the order start, transfer, stop.
- R7: Status bits are BUSY=0, ERROR=1, ADRNAK=2, DATNAK=3, ARBLOST=4, IDLE=5, BUSBUSY=6, and all are zero during reset. After reset, IDLE is 1 exactly when the mode is Idle and BUSY=0.
- R8: A NACK on the start step sets ADRNAK and ERROR. The remaining steps are skipped and the block rests in the mode of the command's direction, so that a STOP can close the bus.
- R9: A NACK on a send step sets DATNAK and ERROR. Any stop step is skipped and the block rests in Transmit.
- R10: Arbitration loss on any step sets ARBLOST and ERROR and drops the block to Idle without a stop request.
- R11: irq is set when a legal command finishes or aborts. It stays set until irq_clr, and a completion in the same cycle as irq_clr wins.
- R12: BUSBUSY is set by bus_start_seen and cleared by bus_stop_seen, whoever drove the bus. Start wins when both arrive in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_word | input | 4 | ACK, STOP, START, RUN bits |
| rd_sel | input | 1 | Direction of the next start: 1 receive, 0 send |
| irq_clr | input | 1 | Clears the interrupt flag |
| eng_req | output | 1 | Primitive request to the byte engine |
| eng_op | output | 3 | Primitive code |
| eng_done | input | 1 | Engine finished the requested primitive |
| eng_nack | input | 1 | Address or data not acknowledged (with eng_done) |
| eng_arb_lost | input | 1 | Arbitration lost (with eng_done) |
| bus_start_seen | input | 1 | START condition observed on the bus |
| bus_stop_seen | input | 1 | STOP condition observed on the bus |
| status | output | 7 | Status word |
| irq | output | 1 | Sticky interrupt flag |

## Verification
The assertions check, on every cycle, the properties of a single step:
- the request handshake stays stable until done;
- a dropped command never raises BUSY;
- an address NACK or arbitration loss ends the command at once and lands in the right mode;
- ERROR always has a cause;
- the interrupt stays sticky;
- BUSBUSY follows bus starts.

Only the bench scenarios can show that each mode and control pattern expands into the correct op sequence. The same applies to the mode left after a command, which is visible only through the IDLE bit and the way the next command decodes. The scenarios also cover writes made while busy, which must be dropped.

// File: rtl/i2c_seq_pkg.sv
package i2c_seq_pkg;
  localparam int CTL_W     = 4;
  localparam int CTL_RUN   = 0;
  localparam int CTL_START = 1;
  localparam int CTL_STOP  = 2;
  localparam int CTL_ACK   = 3;

  localparam int STAT_W  = 7;
  localparam int SB_BUSY = 0;
  localparam int SB_ERR  = 1;
  localparam int SB_ADR  = 2;
  localparam int SB_DAT  = 3;
  localparam int SB_ARB  = 4;
  localparam int SB_IDLE = 5;
  localparam int SB_BUS  = 6;

  localparam int STEP_N  = 3;   // 0 start, 1 transfer, 2 stop
  localparam int OP_W    = 3;

  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_TX = 2'd1, ST_RX = 2'd2} mode_e;

  typedef enum logic [OP_W-1:0] {
    OP_START = 3'd0, OP_RSTART = 3'd1, OP_SEND = 3'd2,
    OP_RECV_ACK = 3'd3, OP_RECV_NACK = 3'd4, OP_STOP = 3'd5
  } op_e;

  typedef struct packed {
    logic [STEP_N-1:0] steps;
    op_e               xop;
    logic              send;
    mode_e             fin;
    mode_e             hold;
  } plan_t;
endpackage

// File: rtl/i2c_seq_rst_sync.sv
module i2c_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sh_q[STAGES-1];
endmodule

// File: rtl/i2c_seq_decode.sv
module i2c_seq_decode
  import i2c_seq_pkg::*;
(
  input  mode_e             cur,
  input  logic [CTL_W-1:0]  ctl,
  input  logic              rd,
  output logic              legal,
  output plan_t             plan
);
  logic run, sta, sto, ack;
  op_e  rx_op;

  assign run   = ctl[CTL_RUN];
  assign sta   = ctl[CTL_START];
  assign sto   = ctl[CTL_STOP];
  assign ack   = ctl[CTL_ACK];
  assign rx_op = ack ? OP_RECV_ACK : OP_RECV_NACK;

  always_comb begin
    legal      = 1'b0;
    plan.steps = '0;
    plan.xop   = OP_SEND;
    plan.send  = 1'b1;
    plan.fin   = cur;
    plan.hold  = cur;
    if (sta && run) begin
      // start or repeated start: same decode from every mode
      if (!(rd && ack && sto)) begin
        legal      = 1'b1;
        plan.steps = {sto, 1'b1, 1'b1};
        plan.send  = !rd;
        plan.xop   = rd ? rx_op : OP_SEND;
        plan.hold  = rd ? ST_RX : ST_TX;
        plan.fin   = sto ? ST_IDLE : (rd ? ST_RX : ST_TX);
      end
    end else if (cur != ST_IDLE && !sta) begin
      plan.send = (cur == ST_TX);
      plan.xop  = (cur == ST_TX) ? OP_SEND : rx_op;
      unique case ({sto, run})
        2'b01: begin legal = 1'b1; plan.steps = 3'b010; end
        2'b10: begin legal = 1'b1; plan.steps = 3'b100; plan.fin = ST_IDLE; end
        2'b11: begin
          if (!(cur == ST_RX && ack)) begin
            legal = 1'b1; plan.steps = 3'b110; plan.fin = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/i2c_seq_core.sv
module i2c_seq_core
  import i2c_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl,
  input  logic             rd,
  input  logic             eng_done,
  input  logic             eng_nack,
  input  logic             eng_arb,
  output logic             eng_req,
  output op_e              eng_op,
  output logic             busy,
  output logic             go,
  output logic             fin,
  output logic             adr_nack,
  output logic             dat_nack,
  output logic             arb_lost,
  output logic             idle_nxt
);
  mode_e             mode_q, mode_d;
  logic              busy_q, busy_d;
  logic              rst_q, rst_d;
  plan_t             plan_q, plan_d, dec_plan;
  logic [STEP_N-1:0] steps_d;
  logic              legal;

  i2c_seq_decode u_dec (.cur(mode_q), .ctl(ctl), .rd(rd), .legal(legal), .plan(dec_plan));

  always_comb begin
    if (plan_q.steps[0])      eng_op = rst_q ? OP_RSTART : OP_START;
    else if (plan_q.steps[1]) eng_op = plan_q.xop;
    else                      eng_op = OP_STOP;
  end
  assign eng_req = busy_q;
  assign busy    = busy_q;

  always_comb begin
    mode_d = mode_q; busy_d = busy_q; rst_d = rst_q; plan_d = plan_q;
    go = 1'b0; fin = 1'b0; adr_nack = 1'b0; dat_nack = 1'b0; arb_lost = 1'b0;
    steps_d = plan_q.steps & (plan_q.steps - STEP_N'(1));
    if (!busy_q) begin
      if (ctl_wr && legal) begin
        busy_d = 1'b1; plan_d = dec_plan; rst_d = (mode_q != ST_IDLE); go = 1'b1;
      end
    end else if (eng_done) begin
      if (eng_arb) begin
        busy_d = 1'b0; mode_d = ST_IDLE; plan_d.steps = '0; fin = 1'b1; arb_lost = 1'b1;
      end else if (eng_nack && plan_q.steps[0]) begin
        busy_d = 1'b0; mode_d = plan_q.hold; plan_d.steps = '0; fin = 1'b1; adr_nack = 1'b1;
      end else if (eng_nack && plan_q.steps[1:0] == 2'b10 && plan_q.send) begin
        busy_d = 1'b0; mode_d = plan_q.hold; plan_d.steps = '0; fin = 1'b1; dat_nack = 1'b1;
      end else begin
        plan_d.steps = steps_d;
        if (steps_d == '0) begin busy_d = 1'b0; mode_d = plan_q.fin; fin = 1'b1; end
      end
    end
    idle_nxt = (mode_d == ST_IDLE) && !busy_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= ST_IDLE; busy_q <= 1'b0; rst_q <= 1'b0; plan_q <= '0;
    end else begin
      mode_q <= mode_d; busy_q <= busy_d; rst_q <= rst_d; plan_q <= plan_d;
    end
  end

  p_op_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    eng_req && !eng_done |=> eng_req && $stable(eng_op));
  p_drop_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && ctl_wr && !legal |=> !busy_q && $stable(mode_q));
  p_arb_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && eng_done && eng_arb |=> !busy_q && mode_q == ST_IDLE);
  p_adr_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && eng_done && eng_nack && !eng_arb && plan_q.steps[0] |=> !busy_q);
endmodule

// File: rtl/i2c_seq_status.sv
module i2c_seq_status
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              go,
  input  logic              fin,
  input  logic              adr_nack,
  input  logic              dat_nack,
  input  logic              arb_lost,
  input  logic              idle_nxt,
  input  logic              irq_clr,
  input  logic              bus_start,
  input  logic              bus_stop,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic adr_q, dat_q, arb_q, err_q, idle_q, bb_q, irq_q;
  logic adr_d, dat_d, arb_d, err_d, bb_d, irq_d;

  always_comb begin
    adr_d = adr_q; dat_d = dat_q; arb_d = arb_q; err_d = err_q;
    if (go) begin
      adr_d = 1'b0; dat_d = 1'b0; arb_d = 1'b0; err_d = 1'b0;
    end else if (fin) begin
      adr_d = adr_nack; dat_d = dat_nack; arb_d = arb_lost;
      err_d = adr_nack | dat_nack | arb_lost;
    end
    irq_d = fin ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
    bb_d  = bus_start ? 1'b1 : (bus_stop ? 1'b0 : bb_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adr_q <= 1'b0; dat_q <= 1'b0; arb_q <= 1'b0; err_q <= 1'b0;
      idle_q <= 1'b0; bb_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      adr_q <= adr_d; dat_q <= dat_d; arb_q <= arb_d; err_q <= err_d;
      idle_q <= idle_nxt; bb_q <= bb_d; irq_q <= irq_d;
    end
  end

  always_comb begin
    status          = '0;
    status[SB_BUSY] = busy;
    status[SB_ERR]  = err_q;
    status[SB_ADR]  = adr_q;
    status[SB_DAT]  = dat_q;
    status[SB_ARB]  = arb_q;
    status[SB_IDLE] = idle_q;
    status[SB_BUS]  = bb_q;
  end
  assign irq = irq_q;

  p_irq_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q && !irq_clr |=> irq_q);
  p_irq_on_fin_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> irq_q);
  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (adr_q | dat_q | arb_q));
  p_busbsy_set_r12: assert property (@(posedge clk) disable iff (!rst_n)
    bus_start |=> bb_q);
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2c_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr,
  input  logic [CTL_W-1:0]  ctl_word,
  input  logic              rd_sel,
  input  logic              irq_clr,
  output logic              eng_req,
  output logic [OP_W-1:0]   eng_op,
  input  logic              eng_done,
  input  logic              eng_nack,
  input  logic              eng_arb_lost,
  input  logic              bus_start_seen,
  input  logic              bus_stop_seen,
  output logic [STAT_W-1:0] status,
  output logic              irq
);
  logic rst_n_s, busy, go, fin, adr_nack, dat_nack, arb_lost, idle_nxt;
  op_e  op;

  i2c_seq_rst_sync #(.STAGES(2)) u_rst (.clk(clk), .rst_n(rst_n), .rst_n_s(rst_n_s));

  i2c_seq_core u_core (
    .clk(clk), .rst_n(rst_n_s), .ctl_wr(ctl_wr), .ctl(ctl_word), .rd(rd_sel),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_arb(eng_arb_lost),
    .eng_req(eng_req), .eng_op(op), .busy(busy), .go(go), .fin(fin),
    .adr_nack(adr_nack), .dat_nack(dat_nack), .arb_lost(arb_lost), .idle_nxt(idle_nxt)
  );

  i2c_seq_status u_stat (
    .clk(clk), .rst_n(rst_n_s), .busy(busy), .go(go), .fin(fin),
    .adr_nack(adr_nack), .dat_nack(dat_nack), .arb_lost(arb_lost), .idle_nxt(idle_nxt),
    .irq_clr(irq_clr), .bus_start(bus_start_seen), .bus_stop(bus_stop_seen),
    .status(status), .irq(irq)
  );

  assign eng_op = op;
endmodule

// File: tb/tb_i2c_cmd_seq.sv
module tb_i2c_cmd_seq;
  logic       clk, rst_n, ctl_wr, rd_sel, irq_clr, eng_req, eng_done, eng_nack, eng_arb_lost;
  logic       bus_start_seen, bus_stop_seen, irq;
  logic [3:0] ctl_word;
  logic [2:0] eng_op;
  logic [6:0] status;

  int checks = 0, fails = 0;
  int req_idx = 0, nack_at = -1, arb_at = -1, lat = 0;
  string cur_req = "R1";
  logic [2:0] exp_q[$];

  localparam logic [6:0] S_IDLE = 7'b0100000, S_ACT = 7'b0000000;

  i2c_cmd_seq dut (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // engine model and monitor: pops expected ops as requests appear
  initial begin
    eng_done = 1'b0; eng_nack = 1'b0; eng_arb_lost = 1'b0;
    forever begin
      @(negedge clk);
      if (eng_done) begin
        eng_done = 1'b0; eng_nack = 1'b0; eng_arb_lost = 1'b0;
      end else if (rst_n && eng_req) begin
        logic [2:0] op;
        op = eng_op;
        for (int w = 0; w < lat; w++) begin
          @(negedge clk);
          check(eng_req && eng_op == op, "R6", eng_op, op);
        end
        if (exp_q.size() == 0) check(1'b0, cur_req, op, 7);
        else begin
          logic [2:0] e;
          e = exp_q.pop_front();
          check(op == e, cur_req, op, e);
        end
        eng_nack = (req_idx == nack_at);
        eng_arb_lost = (req_idx == arb_at);
        req_idx++;
        eng_done = 1'b1;
      end
    end
  end

  task automatic run(input logic [3:0] c, input logic d, input int n,
                     input int o0, input int o1, input int o2,
                     input int nk, input int ab, input bit poke,
                     input logic [6:0] exp_st, input string req);
    int guard;
    req_idx = 0; nack_at = nk; arb_at = ab; cur_req = req;
    if (n > 0) exp_q.push_back(3'(o0));
    if (n > 1) exp_q.push_back(3'(o1));
    if (n > 2) exp_q.push_back(3'(o2));
    @(negedge clk); ctl_word = c; rd_sel = d; ctl_wr = 1'b1;
    @(negedge clk);
    if (poke) begin ctl_word = 4'b0101; @(negedge clk); end
    ctl_wr = 1'b0;
    guard = 0;
    while (status[0] && guard < 1000) begin @(negedge clk); guard++; end
    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(status == exp_st, req, status, exp_st);
    check(irq == (n > 0), req, irq, n > 0);
    irq_clr = 1'b1; @(negedge clk); irq_clr = 1'b0;
    @(negedge clk);
    check(irq == 1'b0, "R11", irq, 0);
    exp_q.delete();
    nack_at = -1; arb_at = -1;
  endtask

  initial begin
    bit finished;
    finished = 1'b0;
    rst_n = 1'b0; ctl_wr = 1'b0; ctl_word = '0; rd_sel = 1'b0; irq_clr = 1'b0;
    bus_start_seen = 1'b0; bus_stop_seen = 1'b0;
    repeat (3) @(negedge clk);
    check(status == 7'd0, "R7", status, 0);
    check(irq == 1'b0 && eng_req == 1'b0, "R7", irq, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(status == S_IDLE, "R7", status, S_IDLE);

    run(4'b0111, 1'b0, 3, 0, 2, 5, -1, -1, 0, S_IDLE, "R1");
    run(4'b1011, 1'b0, 2, 0, 2, 0, -1, -1, 0, S_ACT,  "R1");
    run(4'b0001, 1'b0, 1, 2, 0, 0, -1, -1, 0, S_ACT,  "R3");
    run(4'b0000, 1'b0, 0, 0, 0, 0, -1, -1, 0, S_ACT,  "R5");
    run(4'b0010, 1'b0, 0, 0, 0, 0, -1, -1, 0, S_ACT,  "R5");
    run(4'b1011, 1'b1, 2, 1, 3, 0, -1, -1, 0, S_ACT,  "R3");
    run(4'b0001, 1'b0, 1, 4, 0, 0, -1, -1, 0, S_ACT,  "R4");
    run(4'b1001, 1'b0, 1, 3, 0, 0, -1, -1, 0, S_ACT,  "R4");
    run(4'b1101, 1'b0, 0, 0, 0, 0, -1, -1, 0, S_ACT,  "R4");
    run(4'b0101, 1'b0, 2, 4, 5, 0, -1, -1, 0, S_IDLE, "R4");
    run(4'b0011, 1'b1, 2, 0, 4, 0, -1, -1, 0, S_ACT,  "R2");
    run(4'b0100, 1'b0, 1, 5, 0, 0, -1, -1, 0, S_IDLE, "R4");
    run(4'b0111, 1'b1, 3, 0, 4, 5, -1, -1, 0, S_IDLE, "R2");
    run(4'b1111, 1'b1, 0, 0, 0, 0, -1, -1, 0, S_IDLE, "R2");
    run(4'b0100, 1'b0, 0, 0, 0, 0, -1, -1, 0, S_IDLE, "R5");
    run(4'b0011, 1'b0, 2, 0, 2, 0, -1, -1, 0, S_ACT,  "R1");
    run(4'b0101, 1'b0, 2, 2, 5, 0, -1, -1, 0, S_IDLE, "R3");
    run(4'b0011, 1'b0, 2, 0, 2, 0, -1, -1, 0, S_ACT,  "R1");
    run(4'b0111, 1'b0, 3, 1, 2, 5, -1, -1, 0, S_IDLE, "R3");
    run(4'b0011, 1'b0, 2, 0, 2, 0, -1, -1, 0, S_ACT,  "R1");
    run(4'b0100, 1'b0, 1, 5, 0, 0, -1, -1, 0, S_IDLE, "R3");
    run(4'b1011, 1'b1, 2, 0, 3, 0, -1, -1, 0, S_ACT,  "R2");
    run(4'b0011, 1'b0, 2, 1, 2, 0, -1, -1, 0, S_ACT,  "R4");
    run(4'b0100, 1'b0, 1, 5, 0, 0, -1, -1, 0, S_IDLE, "R3");
    // address NACK in both directions
    run(4'b0111, 1'b0, 1, 0, 0, 0, 0, -1, 0, 7'b0000110, "R8");
    run(4'b0100, 1'b0, 1, 5, 0, 0, -1, -1, 0, S_IDLE, "R8");
    run(4'b0011, 1'b1, 1, 0, 0, 0, 0, -1, 0, 7'b0000110, "R8");
    run(4'b0001, 1'b0, 1, 4, 0, 0, -1, -1, 0, S_ACT, "R8");
    run(4'b0100, 1'b0, 1, 5, 0, 0, -1, -1, 0, S_IDLE, "R8");
    // data NACK
    run(4'b0111, 1'b0, 2, 0, 2, 0, 1, -1, 0, 7'b0001010, "R9");
    run(4'b0001, 1'b0, 1, 2, 0, 0, -1, -1, 0, S_ACT, "R9");
    run(4'b0100, 1'b0, 1, 5, 0, 0, -1, -1, 0, S_IDLE, "R9");
    // arbitration loss
    run(4'b0111, 1'b0, 2, 0, 2, 0, -1, 1, 0, 7'b0110010, "R10");
    run(4'b0011, 1'b1, 1, 0, 0, 0, -1, 0, 0, 7'b0110010, "R10");
    // write while busy is dropped
    run(4'b0011, 1'b0, 2, 0, 2, 0, -1, -1, 1, S_ACT, "R5");
    run(4'b0100, 1'b0, 1, 5, 0, 0, -1, -1, 0, S_IDLE, "R5");
    // slow engine
    lat = 3;
    run(4'b0111, 1'b0, 3, 0, 2, 5, -1, -1, 0, S_IDLE, "R6");
    lat = 0;
    // bus busy tracking
    @(negedge clk); bus_start_seen = 1'b1; @(negedge clk); bus_start_seen = 1'b0;
    check(status[6] == 1'b1, "R12", status[6], 1);
    bus_stop_seen = 1'b1; @(negedge clk); bus_stop_seen = 1'b0;
    check(status[6] == 1'b0, "R12", status[6], 0);
    bus_start_seen = 1'b1; bus_stop_seen = 1'b1; @(negedge clk);
    bus_start_seen = 1'b0; bus_stop_seen = 1'b0;
    check(status[6] == 1'b1, "R12", status[6], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule